// File: doc/BRIEF.md
# Two-Channel Converter Serial Output Controller

This block is the digital front end of a two-input, 12-bit successive-approximation converter, seen from the device side. A host pulls an active-low select line low and toggles a serial clock. The block answers on a serial data line that it releases whenever select is high. Both host lines are brought into one system clock domain, and their edges are detected there. The level of the serial clock at the moment select falls chooses how the frame is timed. If the clock is low, the host clock paces the conversion itself (external mode). If the clock is high, an internal timer of `CONV_CYC` system cycles stands in for the on-chip oscillator, and the line goes high when the result is ready (internal mode).

The analog conversion is not modelled. Each input's result arrives on a parallel port and is captured at the sampling instant, which the block marks with a one-cycle strobe. Each select frame converts the other input, starting with input 0 after reset. Every frame carries three leading ones, a channel bit and the captured word MSB first. The output is a data and output-enable pair, so a pad or the bench can form the high-impedance state.

Top module: `adc_serial_if`

## Requirements
- R1: While and after reset, `sdo_oe` and `sample_stb` are 0, and the first frame after reset converts input 0.
- R2: A select fall seen while the serial clock is low starts an external-mode frame. A select fall seen while it is high starts an internal-mode frame.
- R3: Every select fall, including one whose frame is aborted, switches to the other input. The channel bit is 0 for input 0 and 1 for input 1.
- R4: In external mode the word is captured, and `sample_stb` pulses for one cycle, on the second serial clock fall of the frame. Later changes on the data ports do not alter that frame.
- R5: In internal mode the first serial clock fall captures the word and starts the timer. `sdo` goes to 1 (end of conversion) exactly `CONV_CYC` system cycles later, never earlier, and serial clock falls during the timer do not advance the frame.
- R6: The 16 frame bits are 1, 1, 1, the channel bit, then data bit 11 down to bit 0. In internal mode the first 1 is the end-of-conversion level.
- R7: While enabled, `sdo` changes only one cycle after a detected serial clock fall or at end of conversion. From select fall until the first bit, it is 0.
- R8: Serial clock falls after the last data bit shift out 0.
- R9: Select high disables `sdo_oe` and aborts any frame or conversion in progress. This holds even when the abort lands in the same cycle as end of conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| ch0_data | input | DATA_W | Result word for input 0 |
| ch1_data | input | DATA_W | Result word for input 1 |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| sample_stb | output | 1 | One-cycle pulse at the sampling instant |

## Verification
The two events that can meet in one cycle are the timer expiring in internal mode and a select rise that aborts the frame. The bench releases select exactly `CONV_CYC` cycles after the sampling serial clock fall, so that both synchronised events reach the control logic on the same edge. It then judges against its behavioural model that the abort wins: the enable drops and no end-of-conversion level is driven. The same model is compared every cycle across external frames, internal frames, extended reads and early aborts. Each frame is also rebuilt from the bits the host reads on rising serial clock edges.

// File: rtl/adc_serial_if.sv
module adc_serial_if #(
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] ch0_data,
  input  logic [DATA_W-1:0] ch1_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sample_stb
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int POS_W   = $clog2(FRAME_W + 2);
  localparam int CNT_W   = $clog2(CONV_CYC + 1);
  localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_EXT, S_IWAIT, S_ICONV, S_IREAD} st_t;

  st_t               st;
  logic [2:0]        cs_sync, sck_sync;
  logic [POS_W-1:0]  pos, pos_nx;
  logic [CNT_W-1:0]  cnt;
  logic              cur_ch;
  logic [DATA_W-1:0] smp;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W+1:0] seq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sync  <= 3'b111;
      sck_sync <= 3'b000;
    end else begin
      cs_sync  <= {cs_sync[1:0], cs_n};
      sck_sync <= {sck_sync[1:0], sclk};
    end

  wire cs_fall  =  cs_sync[2] & ~cs_sync[1];
  wire cs_rise  = ~cs_sync[2] &  cs_sync[1];
  wire sck_fall =  sck_sync[2] & ~sck_sync[1];

  assign frame  = {3'b111, cur_ch, smp};
  assign pos_nx = (pos == POS_END) ? pos : pos + 1'b1;

  always_comb begin
    seq = '0;
    for (int i = 1; i <= FRAME_W; i++) seq[i] = frame[FRAME_W-i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sdo_oe <= 1'b0; sdo <= 1'b0; pos <= '0; cnt <= '0;
      cur_ch <= 1'b1; smp <= '0; sample_stb <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      if (cs_rise) begin
        st <= S_IDLE; sdo_oe <= 1'b0; sdo <= 1'b0;
      end else if (cs_fall) begin
        st     <= sck_sync[1] ? S_IWAIT : S_EXT;
        sdo_oe <= 1'b1; sdo <= 1'b0; pos <= '0;
        cur_ch <= ~cur_ch;
      end else begin
        case (st)
          S_EXT: if (sck_fall) begin
            pos <= pos_nx;
            sdo <= seq[pos_nx];
            if (pos_nx == POS_W'(2)) begin
              smp <= cur_ch ? ch1_data : ch0_data;
              sample_stb <= 1'b1;
            end
          end
          S_IWAIT: if (sck_fall) begin
            smp <= cur_ch ? ch1_data : ch0_data;
            sample_stb <= 1'b1;
            cnt <= CNT_W'(CONV_CYC - 1);
            st  <= S_ICONV;
          end
          S_ICONV:
            if (cnt == '0) begin
              st <= S_IREAD; pos <= POS_W'(1); sdo <= 1'b1;
            end else cnt <= cnt - 1'b1;
          S_IREAD: if (sck_fall) begin
            pos <= pos_nx;
            sdo <= seq[pos_nx];
          end
          default: ;
        endcase
      end
    end

  logic [CNT_W:0] since_smp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_smp <= '0;
    else if (sample_stb) since_smp <= 1;
    else if (since_smp < (CNT_W+1)'(CONV_CYC)) since_smp <= since_smp + 1'b1;

  p_hiz_when_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sync[2] && cs_sync[1]) |-> !sdo_oe);

  p_eoc_not_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IREAD && $past(st) == S_ICONV) |-> (since_smp >= (CNT_W+1)'(CONV_CYC)));

  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> ($past(sck_fall) || $past(st) == S_ICONV));

  p_sample_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> sdo_oe);

  p_ext_second_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && $past(st) == S_EXT) |-> (pos == POS_W'(2)));
endmodule

// File: tb/test_adc_serial_if.sv
`timescale 1ns/1ps
module test_adc_serial_if;
  localparam int DW = 12;
  localparam int N  = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [DW-1:0] ch0_data = 12'hA5C, ch1_data = 12'h3E1;
  logic sdo, sdo_oe, sample_stb;

  adc_serial_if #(.DATA_W(DW), .CONV_CYC(N)) i_adc_serial_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .ch0_data(ch0_data), .ch1_data(ch1_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .sample_stb(sample_stb));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int hcs[4], hsk[4];
  int m_st, m_pos, m_rem, m_cur, m_nxt;
  bit m_oe, m_dout, m_stb;
  logic [DW-1:0] m_data;

  function automatic bit mbit(int p);
    if (p >= 1 && p <= 3) return 1'b1;
    if (p == 4) return m_cur[0];
    if (p >= 5 && p <= DW + 4) return m_data[DW + 4 - p];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hcs[i] = 1; hsk[i] = 0; end
      m_st = 0; m_pos = 0; m_rem = 0; m_cur = 1; m_nxt = 0;
      m_oe = 0; m_dout = 0; m_stb = 0; m_data = '0;
    end else begin
      for (int i = 3; i > 0; i--) begin hcs[i] = hcs[i-1]; hsk[i] = hsk[i-1]; end
      hcs[0] = int'(cs_n); hsk[0] = int'(sclk);
      m_stb = 0;
      if (hcs[3] == 0 && hcs[2] == 1) begin
        m_st = 0; m_oe = 0; m_dout = 0;
      end else if (hcs[3] == 1 && hcs[2] == 0) begin
        m_oe = 1; m_dout = 0; m_pos = 0; m_cur = m_nxt; m_nxt = 1 - m_nxt;
        m_st = (hsk[2] == 1) ? 2 : 1;
      end else begin
        bit sf;
        sf = (hsk[3] == 1 && hsk[2] == 0);
        case (m_st)
          1: if (sf) begin
            if (m_pos < DW + 5) m_pos++;
            if (m_pos == 2) begin
              m_data = (m_cur == 1) ? ch1_data : ch0_data; m_stb = 1;
            end
            m_dout = mbit(m_pos);
          end
          2: if (sf) begin
            m_data = (m_cur == 1) ? ch1_data : ch0_data; m_stb = 1;
            m_rem = N; m_st = 3;
          end
          3: begin
            m_rem--;
            if (m_rem == 0) begin m_st = 4; m_pos = 1; m_dout = 1; end
          end
          4: if (sf) begin
            if (m_pos < DW + 5) m_pos++;
            m_dout = mbit(m_pos);
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      vectors++;
      if (sdo_oe !== m_oe || sample_stb !== m_stb || (m_oe && sdo !== m_dout)) begin
        miscompares++;
        $display("FAIL %s cycle %0d: oe/stb/sdo actual %b%b%b expected %b%b%b",
                 tag, cycles, sdo_oe, sample_stb, sdo, m_oe, m_stb, m_dout);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string t, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  int exp_ch = 0;

  function automatic logic [31:0] expect_word(int ch, logic [DW-1:0] d, int nbits);
    logic [31:0] w;
    w = {3'b111, ch[0], d};
    if (nbits > 16) w = w << (nbits - 16);
    return w;
  endfunction

  // external-mode frame: reads nbits on rising sclk; optional data change after capture
  task automatic ext_frame(int nbits, bit alter, output logic [31:0] word);
    word = '0;
    sclk = 0; cyc(6); cs_n = 0; cyc(8);
    sclk = 1; cyc(6);
    for (int i = 0; i < nbits; i++) begin
      sclk = 0; cyc(6);
      word = {word[30:0], sdo};
      sclk = 1; cyc(6);
      if (alter && i == 2) begin ch0_data = ~ch0_data; ch1_data = ~ch1_data; end
    end
    cs_n = 1; sclk = 0; cyc(10);
  endtask

  task automatic int_frame(output logic [31:0] word, output bit early_hi);
    word = '0;
    sclk = 1; cyc(6); cs_n = 0; cyc(8);
    sclk = 0; cyc(6); sclk = 1;
    cyc(N - 12);
    early_hi = sdo;
    // extra sclk pulse during conversion must be ignored
    sclk = 0; cyc(4); sclk = 1; cyc(20);
    word = {word[30:0], sdo};
    for (int i = 1; i < 16; i++) begin
      sclk = 0; cyc(6);
      word = {word[30:0], sdo};
      sclk = 1; cyc(6);
    end
    cs_n = 1; sclk = 0; cyc(10);
  endtask

  initial begin
    logic [31:0] w;
    logic [DW-1:0] d;
    bit eh;
    cyc(3);
    chk(sdo_oe === 1'b0 && sample_stb === 1'b0, "R1 reset outputs", {sdo_oe, sample_stb}, 0);
    rst_n = 1; cyc(5);
    chk(sdo_oe === 1'b0, "R9 idle high-z", sdo_oe, 0);

    tag = "R2"; d = ch0_data;
    ext_frame(16, 0, w);
    chk(w[15:0] == expect_word(0, d, 16), "R1 R6 first frame input 0", w[15:0], expect_word(0, d, 16));
    exp_ch = 1;

    tag = "R5"; d = ch1_data;
    int_frame(w, eh);
    chk(eh == 1'b0, "R5 no early EOC", eh, 0);
    chk(w[15:0] == expect_word(1, d, 16), "R5 R6 internal frame input 1", w[15:0], expect_word(1, d, 16));
    exp_ch = 0;

    tag = "R4"; d = ch0_data;
    ext_frame(16, 1, w);
    chk(w[15:0] == expect_word(0, d, 16), "R4 capture at second fall", w[15:0], expect_word(0, d, 16));
    exp_ch = 1;

    tag = "R8"; d = ch1_data;
    ext_frame(20, 0, w);
    chk(w[19:0] == expect_word(1, d, 20), "R8 trailing zeros", w[19:0], expect_word(1, d, 20));
    exp_ch = 0;

    tag = "R9";
    sclk = 0; cyc(6); cs_n = 0; cyc(20); cs_n = 1; cyc(10);
    chk(sdo_oe === 1'b0, "R9 aborted frame released", sdo_oe, 0);
    exp_ch = 1;

    tag = "R3"; d = ch1_data;
    ext_frame(16, 0, w);
    chk(w[15:0] == expect_word(1, d, 16), "R3 aborted frame still toggles", w[15:0], expect_word(1, d, 16));
    exp_ch = 0;

    tag = "R9";
    sclk = 1; cyc(6); cs_n = 0; cyc(8); sclk = 0; cyc(10);
    cs_n = 1; cyc(N + 10);
    chk(sdo_oe === 1'b0, "R9 abort during conversion", sdo_oe, 0);
    exp_ch = 1;

    tag = "R9";
    sclk = 1; cyc(6); cs_n = 0; cyc(8);
    sclk = 0; cyc(N); cs_n = 1; sclk = 1; cyc(12);
    chk(sdo_oe === 1'b0, "R9 abort meets EOC", sdo_oe, 0);
    exp_ch = 0;

    tag = "R7"; ch0_data = 12'h001; d = ch0_data;
    ext_frame(16, 0, w);
    chk(w[15:0] == expect_word(0, d, 16), "R7 R6 low-value frame", w[15:0], expect_word(0, d, 16));
    exp_ch = 1;

    tag = "R2"; ch1_data = 12'hFFF; d = ch1_data;
    int_frame(w, eh);
    chk(w[15:0] == expect_word(1, d, 16), "R2 R3 internal all-ones", w[15:0], expect_word(1, d, 16));

    cyc(20);
    finish_run();
  end
endmodule